// File: doc/BRIEF.md
# Four-Event Edge Capture Timer

This block measures the timing of edges on a single digital input against a free-running timestamp counter. A modulo event pointer walks through four capture slots. Each slot picks its own active edge and its own timing style. An absolute slot latches the running count and leaves the counter alone. A delta slot latches the count and then restarts the counter, so the next slot measures the interval since that edge.

Software configures the block through a small word-addressed register port. The port gives access to a control word, the interrupt enables, the event flags, a re-arm strobe, the live counter and the four capture results. A level interrupt output is raised whenever an enabled flag is set. A typical use is to capture on rising, falling, rising and falling edges, with only the last slot in delta mode. In that setup the four results give the low time, one period, one period plus the low time, and two periods of a square wave, and they stay the same from one sequence to the next.

Top module: `edge_cap4`

## Requirements
- R1: After reset, the control word, interrupt enables, flags, counter and all four capture registers read 0, and the interrupt output is low.
- R2: While the run bit (control bit 12) is 1, the counter (address 4) rises by exactly one per clock. While the run bit is 0, the counter holds its value.
- R3: Captures fill the slots in order: slot 1 (address 8) first, then slots 2, 3 and 4 (addresses 9 to 11). The slot being filled reacts only to its selected edge: control bit i−1 set to 1 selects a falling edge for slot i, and 0 selects a rising edge.
- R4: When a slot's delta bit (control bit 3+i for slot i) is 1, that slot latches the count and the counter continues from 1 on the next clock. With slots 1 to 3 absolute, slot 4 delta, polarities rising/falling/rising/falling, and an input with a high time of 6 clocks and a low time of 14 clocks, steady state gives the values 14, 20, 34 and 40.
- R5: The two-bit wrap field (control bits 9:8) holds the index of the last slot, counted from 0. After that slot captures, the pointer returns to slot 1, and slots with a higher index are never written.
- R6: With the one-shot bit (control bit 10) set, capturing stops after the wrap slot is filled. Writing 1 to bit 0 of the re-arm address (3) returns the pointer to slot 1 and allows captures again.
- R7: While the load-enable bit (control bit 11) is 0, edges have no effect: capture registers, flags and the event pointer all stay unchanged.
- R8: Each capture into slot i sets flag bit i−1 (address 2). Writing 1 to a flag bit clears it. The interrupt output is the OR of the flags ANDed with the enables (address 1, same bit layout).
- R9: The counter wraps silently from all ones to 0, and the wrap sets flag bit 4.
- R10: An input level change that is set up before a clock edge is captured on the third rising clock edge after it. The capture latches the counter value that was present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cap_in | input | 1 | Asynchronous input whose edges are timed |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, high while any enabled flag is set |

## Verification
A write takes effect at the next clock edge. The counter starts to move one edge after that, and read data follows the address within the same cycle. An input change reaches its capture register and flag three edges after it is driven, and the interrupt is due at that same edge. The bench therefore changes the input and the register port only on falling clock edges. It counts the falling edges it waits after each stimulus so that it reads at least one half-cycle after the result is due. The absolute checks use a counter origin set by the write that starts the counter, and the other checks compare capture values with one another.

// File: rtl/edge_cap4_pkg.sv
package edge_cap4_pkg;
  localparam int ADDR_W = 4;
  localparam int NSLOT  = 4;
  localparam int PTR_W  = $clog2(NSLOT);

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'h1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'h2;
  localparam logic [ADDR_W-1:0] A_REARM = 4'h3;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'h4;

  // control word, MSB first: run at bit 12 down to polarity at bits 3:0
  typedef struct packed {
    logic             run;
    logic             load_en;
    logic             oneshot;
    logic [PTR_W-1:0] wrap;
    logic [NSLOT-1:0] delta;
    logic [NSLOT-1:0] fall;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/edge_cap4_sync.sv
module edge_cap4_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb sh_d = {sh_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
  assign fall = ~sh_q[STAGES-1] & prev_q;

  AST_EDGE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R10
endmodule

// File: rtl/edge_cap4_counter.sv
module edge_cap4_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             delta_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run | delta_hit;
    if (delta_hit) cnt_d = {{(CNT_W-1){1'b0}}, run};
    else           cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign ovf = run & ~delta_hit & (&cnt_q);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !delta_hit |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !delta_hit |=> $stable(cnt_q)); // R2
  AST_DELTA_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    run && delta_hit |=> cnt_q == 1); // R4
endmodule

// File: rtl/edge_cap4_seq.sv
module edge_cap4_seq
  import edge_cap4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [NSLOT-1:0] fall_sel,
  input  logic             load_en,
  input  logic             oneshot,
  input  logic [PTR_W-1:0] wrap,
  input  logic             rearm,
  output logic             fire,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             armed_q, armed_d;
  logic             edge_hit;

  always_comb begin
    edge_hit = fall_sel[ptr_q] ? fall : rise;
    fire     = edge_hit & load_en & (armed_q | ~oneshot);
    ptr_d    = ptr_q;
    armed_d  = armed_q;
    if (rearm) begin
      ptr_d   = '0;
      armed_d = 1'b1;
    end else if (fire) begin
      if (ptr_q == wrap) begin
        ptr_d = '0;
        if (oneshot) armed_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      ptr_q   <= ptr_d;
      armed_q <= armed_d;
    end
  end

  assign ptr = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !rearm && ptr_q == wrap |=> ptr_q == 0); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !rearm && oneshot && ptr_q == wrap |=> !armed_q); // R6
  AST_REARM_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> ptr_q == 0 && armed_q); // R6
endmodule

// File: rtl/edge_cap4.sv
module edge_cap4
  import edge_cap4_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int FLAG_W = NSLOT + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ctrl_t                        ctrl_q, ctrl_d;
  logic [FLAG_W-1:0]            ien_q, ien_d, flags_q, flags_d, flag_set, flag_clr;
  logic [NSLOT-1:0][CNT_W-1:0]  cap_q;
  logic                         rise, fall, fire, rearm, delta_hit, ovf;
  logic [PTR_W-1:0]             ptr;
  logic [CNT_W-1:0]             cnt;
  logic [NSLOT-1:0]             slot_hit;

  edge_cap4_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(cap_in), .rise(rise), .fall(fall));

  edge_cap4_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .rise(rise), .fall(fall),
    .fall_sel(ctrl_q.fall), .load_en(ctrl_q.load_en), .oneshot(ctrl_q.oneshot),
    .wrap(ctrl_q.wrap), .rearm(rearm), .fire(fire), .ptr(ptr));

  edge_cap4_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(ctrl_q.run), .delta_hit(delta_hit),
    .cnt(cnt), .ovf(ovf));

  assign delta_hit = fire & ctrl_q.delta[ptr];
  assign rearm     = wr_en & (addr == A_REARM) & wdata[0];

  // configuration and flag next state
  always_comb begin
    ctrl_d   = ctrl_q;
    ien_d    = ien_q;
    flag_clr = '0;
    if (wr_en && addr == A_CTRL) ctrl_d   = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_en && addr == A_IEN)  ien_d    = wdata[FLAG_W-1:0];
    if (wr_en && addr == A_FLAG) flag_clr = wdata[FLAG_W-1:0];
    flag_set = {ovf, slot_hit};
    flags_d  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ien_q   <= ien_d;
      flags_q <= flags_d;
    end
  end

  // one capture register per slot
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_hit[i] = fire & (ptr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)      cap_q[i] <= '0;
      else if (slot_hit[i]) cap_q[i] <= cnt;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1]) begin
      rdata = DATA_W'(cap_q[addr[PTR_W-1:0]]);
    end else begin
      case (addr)
        A_CTRL:  rdata = DATA_W'(ctrl_q);
        A_IEN:   rdata = DATA_W'(ien_q);
        A_FLAG:  rdata = DATA_W'(flags_q);
        A_CNT:   rdata = DATA_W'(cnt);
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |(flags_q & ien_q);

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fire |=> flags_q[$past(ptr)]); // R8
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_q.load_en |=> $stable(cap_q)); // R7
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf |=> flags_q[NSLOT] && cnt == 0); // R9
endmodule

// File: tb/edge_cap4_bench.sv
module edge_cap4_bench;
  localparam int CW = 12;
  localparam logic [31:0] RUN = 32'h1000, LDEN = 32'h0800, ONES = 32'h0400;

  logic        clk = 1'b0;
  logic        rst_n, cap_in, wr_en, irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, v, a;
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  edge_cap4 #(.CNT_W(CW), .DATA_W(32)) u_edge_cap4 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] ad, output logic [31:0] d);
    addr = ad; #1; d = rdata;
  endtask

  task automatic wr(input logic [3:0] ad, input logic [31:0] d);
    wr_en = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    cap_in = 1'b1; waitn(hi);
    cap_in = 1'b0; waitn(lo);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cap_in = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(3);
  endtask

  task automatic t_reset();  // R1
    do_reset();
    for (int i = 0; i < 5; i++) begin rd(4'(i), v); chk("R1 reg", v, 0); end
    for (int i = 8; i < 12; i++) begin rd(4'(i), v); chk("R1 cap", v, 0); end
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_count();  // R2
    do_reset();
    wr(4'h0, RUN);
    rd(4'h4, a); waitn(10); rd(4'h4, v);
    chk("R2 run step", v, a + 10);
    wr(4'h0, 0);
    rd(4'h4, a); waitn(5); rd(4'h4, v);
    chk("R2 hold", v, a);
  endtask

  task automatic t_latency();  // R10 R3
    do_reset();
    wr(4'h0, RUN | LDEN | 32'h300);
    waitn(5);
    cap_in = 1'b1;
    waitn(2); rd(4'h2, v); chk("R10 not before third edge", v, 0);
    waitn(2);
    rd(4'h8, v); chk("R10 capture value", v, 7);
    rd(4'h2, v); chk("R8 slot1 flag", v, 1);
  endtask

  task automatic t_wrap();  // R5
    do_reset();
    wr(4'h0, RUN | LDEN | 32'h100);
    for (int i = 0; i < 3; i++) pulse(4, 4);
    rd(4'h9, a); rd(4'h8, v);
    chk("R5 slot1 rewritten after wrap", v, a + 8);
    rd(4'hA, v); chk("R5 slot3 untouched", v, 0);
    rd(4'hB, v); chk("R5 slot4 untouched", v, 0);
    rd(4'h2, v); chk("R5 flags", v, 3);
  endtask

  task automatic t_pattern();  // R4 R3
    do_reset();
    wr(4'h0, RUN | LDEN | 32'h300 | 32'h80 | 32'hA);
    for (int i = 0; i < 4; i++) pulse(6, 14);
    rd(4'h8, v); chk("R4 slot1 low time", v, 14);
    rd(4'h9, v); chk("R3 slot2 falling", v, 20);
    rd(4'hA, v); chk("R4 slot3", v, 34);
    rd(4'hB, v); chk("R4 slot4 delta", v, 40);
  endtask

  task automatic t_oneshot();  // R6
    do_reset();
    wr(4'h0, RUN | LDEN | ONES);
    pulse(4, 4);
    rd(4'h8, a);
    pulse(4, 4);
    rd(4'h8, v); chk("R6 stopped after wrap", v, a);
    wr(4'h3, 1);
    pulse(4, 4);
    rd(4'h8, v); chk("R6 rearmed capture", v, a + 17);
  endtask

  task automatic t_loaden();  // R7
    do_reset();
    wr(4'h0, RUN | 32'h300);
    pulse(4, 4); pulse(4, 4);
    rd(4'h2, v); chk("R7 no flags", v, 0);
    rd(4'h8, v); chk("R7 no capture", v, 0);
    wr(4'h0, RUN | LDEN | 32'h300);
    pulse(4, 4);
    rd(4'h2, v); chk("R7 pointer kept at slot1", v, 1);
    rd(4'h9, v); chk("R7 slot2 empty", v, 0);
  endtask

  task automatic t_irq();  // R8
    do_reset();
    wr(4'h1, 32'h8);
    wr(4'h0, RUN | LDEN | 32'h300);
    for (int i = 0; i < 3; i++) pulse(4, 4);
    chk("R8 irq masked", 32'(irq), 0);
    rd(4'h2, v); chk("R8 flags three", v, 7);
    pulse(4, 4);
    chk("R8 irq on slot4", 32'(irq), 1);
    wr(4'h2, 32'h3);
    rd(4'h2, v); chk("R8 partial clear", v, 32'hC);
    wr(4'h2, 32'h8);
    chk("R8 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_ovf();  // R9
    do_reset();
    wr(4'h1, 32'h10);
    wr(4'h0, RUN);
    waitn(4090);
    chk("R9 no irq before wrap", 32'(irq), 0);
    waitn(10);
    rd(4'h4, v); chk("R9 counter wrapped", v, 4);
    rd(4'h2, v); chk("R9 overflow flag", v, 32'h10);
    chk("R9 irq", 32'(irq), 1);
  endtask

  initial begin
    t_reset();
    t_count();
    t_latency();
    t_wrap();
    t_pattern();
    t_oneshot();
    t_loaden();
    t_irq();
    t_ovf();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule